// File: doc/BRIEF.md
# Seven-Channel Host/Processor Mailbox with Interrupt Summary

This block is the shared message area between a host CPU and an attached I/O processor. It holds seven channels. Each channel has an outbound slot (host to processor) and an inbound slot (processor to host). A slot is a 32-byte message buffer plus one state byte. The host and the processor each reach every buffer byte, every state byte and one status byte through their own byte-wide request port. A read returns its data on the cycle after the request.

Each slot follows a four-step handshake. The sender fills the buffer and writes NEW. The receiver writes RCVD and then COMPLETE, leaving its reply in the same buffer. The sender then returns the slot to IDLE. Outbound slots are driven by the host and inbound slots by the processor. The block watches every state-byte write. When an outbound slot reaches COMPLETE it raises a send-done flag. When an inbound slot reaches NEW it raises an arrival flag. Both flags drive one host interrupt line, and the host tells them apart by reading the status byte. The host rings a doorbell flag toward the processor, and the processor clears it.

Top module: `mbx_ctrl`

## Requirements
- R1: After reset, all state bytes read 0 (IDLE), the status byte reads 0, and `irq_o`, `doorbell_o` and `conflict_o` are low.
- R2: Addresses with bit 9 clear select the buffers. The byte address is {dir (bit 8: 0 outbound, 1 inbound), channel (bits 7:5), byte (bits 4:0)}. Any byte written by either port can be read by either port, and the read data appears on the cycle after the request.
- R3: Addresses 0x200 to 0x20F are the state bytes. Bit 3 is dir and bits 2:0 are the channel. A state byte stores any 8-bit value written to it, and both ports read that value back. The encodings are IDLE=0, NEW=1, RCVD=2 and COMPLETE=3.
- R4: A write of 3 to an outbound state byte whose stored value is not 3 sets the send-done flag (status bit 0) on that clock edge.
- R5: A write of 1 to an inbound state byte whose stored value is not 1 sets the arrival flag (status bit 1).
- R6: No other state write sets a flag. This covers values above 3, the other encodings, the other direction, and rewriting the value already stored.
- R7: The status byte at 0x210 reads {4'b0, conflict, doorbell, arrival, send-done}. `irq_o` is high exactly when send-done or arrival is set.
- R8: A host write to 0x210 with bit 0 or bit 1 set clears that flag. A flag-setting write in the same cycle wins over the clear. A processor write to bits 0 and 1 has no effect.
- R9: A host write to 0x210 with bit 2 set raises `doorbell_o`. A processor write to 0x210 with bit 2 set clears it. If both happen in the same cycle, the doorbell is set.
- R10: When both ports write the same state byte in one cycle, the processor's value is stored and only that value is judged for flags. `conflict_o` (status bit 3) then sets and stays set until reset.
- R11: Channel index 7, and addresses outside the buffer, state and status ranges, read 0. Writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_req_i | input | 1 | Host access request |
| host_we_i | input | 1 | Host write (1) or read (0) |
| host_addr_i | input | 10 | Host byte address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, valid the cycle after a read |
| iop_req_i | input | 1 | Processor access request |
| iop_we_i | input | 1 | Processor write (1) or read (0) |
| iop_addr_i | input | 10 | Processor byte address |
| iop_wdata_i | input | 8 | Processor write data |
| iop_rdata_o | output | 8 | Processor read data, valid the cycle after a read |
| irq_o | output | 1 | Host interrupt: send-done OR arrival |
| doorbell_o | output | 1 | Doorbell flag toward the processor |
| conflict_o | output | 1 | Sticky same-byte write clash flag |

## Verification
Complete outbound and inbound handshakes are run on separate channels. They show that only a 3 on an outbound byte or a 1 on an inbound byte raises an interrupt, and that out-of-range values, wrong-direction encodings and same-value rewrites stay silent. Same-cycle patterns are driven on purpose to separate set-over-clear priority from clear-only behaviour:
- an acknowledge together with a new completion;
- a doorbell ring together with a processor clear;
- both ports writing one state byte;
- both ports writing different state bytes.

A long stretch of random mixed traffic is also compared against the cycle model. It covers unmapped and reserved-channel addresses and buffer bytes written by both ports at once.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DW = 8;

  typedef enum logic [DW-1:0] {
    SLOT_IDLE = 8'd0,
    SLOT_NEW  = 8'd1,
    SLOT_RCVD = 8'd2,
    SLOT_DONE = 8'd3
  } slot_st_e;

  localparam int STAT_DONE  = 0;
  localparam int STAT_ARRV  = 1;
  localparam int STAT_BELL  = 2;
  localparam int STAT_CLASH = 3;

  typedef struct packed {
    logic buf_hit;
    logic st_hit;
    logic stat_hit;
    logic ch_ok;
  } dec_t;
endpackage

// File: rtl/mbx_dec.sv
module mbx_dec
  import mbx_pkg::*;
#(
  parameter int NUM_CH    = 7,
  parameter int MSG_BYTES = 32,
  localparam int CH_W      = $clog2(NUM_CH + 1),
  localparam int BYTE_W    = $clog2(MSG_BYTES),
  localparam int AW        = CH_W + BYTE_W + 2,
  localparam int BUF_DEPTH = 2 * NUM_CH * MSG_BYTES,
  localparam int BIDX_W    = $clog2(BUF_DEPTH),
  localparam int SIDX_W    = $clog2(2 * NUM_CH)
) (
  input  logic [AW-1:0]     addr_i,
  output dec_t              dec_o,
  output logic [BIDX_W-1:0] buf_idx_o,
  output logic [SIDX_W-1:0] st_idx_o
);
  localparam logic [AW-1:0] STAT_ADDR = AW'((1 << (AW - 1)) | (1 << (CH_W + 1)));

  logic              buf_dir, st_dir;
  logic [CH_W-1:0]   buf_ch, st_ch;
  logic [BYTE_W-1:0] byte_sel;

  assign buf_dir  = addr_i[AW-2];
  assign buf_ch   = addr_i[BYTE_W +: CH_W];
  assign byte_sel = addr_i[BYTE_W-1:0];
  assign st_dir   = addr_i[CH_W];
  assign st_ch    = addr_i[CH_W-1:0];

  assign dec_o.buf_hit  = !addr_i[AW-1];
  assign dec_o.st_hit   = addr_i[AW-1] && (addr_i[AW-2:CH_W+1] == '0);
  assign dec_o.stat_hit = (addr_i == STAT_ADDR);
  assign dec_o.ch_ok    = addr_i[AW-1] ? (int'(st_ch) < NUM_CH) : (int'(buf_ch) < NUM_CH);

  assign buf_idx_o = BIDX_W'(int'(buf_dir) * NUM_CH * MSG_BYTES
                             + int'(buf_ch) * MSG_BYTES + int'(byte_sel));
  assign st_idx_o  = SIDX_W'(int'(st_dir) * NUM_CH + int'(st_ch));
endmodule

// File: rtl/mbx_buf.sv
module mbx_buf
  import mbx_pkg::*;
#(
  parameter int NUM_CH    = 7,
  parameter int MSG_BYTES = 32,
  localparam int BUF_DEPTH = 2 * NUM_CH * MSG_BYTES,
  localparam int BIDX_W    = $clog2(BUF_DEPTH),
  localparam int MEM_DEPTH = 1 << BIDX_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [1:0]                 we_i,
  input  logic [1:0][BIDX_W-1:0]     idx_i,
  input  logic [1:0][DW-1:0]         wdata_i,
  output logic [1:0][DW-1:0]         rdata_o
);
  logic [DW-1:0] mem_q [MEM_DEPTH];

  // port 1 (processor) is written last and wins a same-byte clash
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (we_i[p]) mem_q[idx_i[p]] <= wdata_i[p];
      end
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    assign rdata_o[p] = mem_q[idx_i[p]];
  end
endmodule

// File: rtl/mbx_state.sv
module mbx_state
  import mbx_pkg::*;
#(
  parameter int NUM_CH = 7,
  localparam int N_SLOT = 2 * NUM_CH,
  localparam int SIDX_W = $clog2(N_SLOT)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             we_i,
  input  logic [1:0][SIDX_W-1:0] idx_i,
  input  logic [1:0][DW-1:0]     wdata_i,
  output logic [1:0][DW-1:0]     rdata_o,
  output logic                   evt_send_o,
  output logic                   evt_recv_o,
  output logic                   clash_o
);
  logic [N_SLOT-1:0][DW-1:0] st_q;
  logic [N_SLOT-1:0]         evt;

  assign clash_o = we_i[0] && we_i[1] && (idx_i[0] == idx_i[1]);

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    localparam logic [DW-1:0] TRIG = (s < NUM_CH) ? SLOT_DONE : SLOT_NEW;
    logic          hsel, psel, wen;
    logic [DW-1:0] wval;

    assign psel = we_i[1] && (int'(idx_i[1]) == s);
    assign hsel = we_i[0] && (int'(idx_i[0]) == s);
    assign wen  = psel || hsel;
    assign wval = psel ? wdata_i[1] : wdata_i[0];
    assign evt[s] = wen && (wval == TRIG) && (st_q[s] != TRIG);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  st_q[s] <= SLOT_IDLE;
      else if (wen) st_q[s] <= wval;
    end
  end

  assign evt_send_o = |evt[NUM_CH-1:0];
  assign evt_recv_o = |evt[N_SLOT-1:NUM_CH];

  for (genvar p = 0; p < 2; p++) begin : g_rd
    assign rdata_o[p] = (int'(idx_i[p]) < N_SLOT) ? st_q[idx_i[p]] : '0;
  end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       evt_send_i,
  input  logic       evt_recv_i,
  input  logic [1:0] ack_i,
  input  logic       ring_i,
  input  logic       bell_clr_i,
  input  logic       clash_i,
  output logic [1:0] int_o,
  output logic       bell_o,
  output logic       err_o
);
  logic [1:0] evt;
  assign evt = {evt_recv_i, evt_send_i};

  // set beats acknowledge, ring beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_o  <= '0;
      bell_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      int_o  <= evt | (int_o & ~ack_i);
      bell_o <= ring_i | (bell_o & !bell_clr_i);
      err_o  <= err_o | clash_i;
    end
  end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int NUM_CH    = 7,
  parameter int MSG_BYTES = 32,
  localparam int CH_W      = $clog2(NUM_CH + 1),
  localparam int BYTE_W    = $clog2(MSG_BYTES),
  localparam int AW        = CH_W + BYTE_W + 2,
  localparam int BUF_DEPTH = 2 * NUM_CH * MSG_BYTES,
  localparam int BIDX_W    = $clog2(BUF_DEPTH),
  localparam int SIDX_W    = $clog2(2 * NUM_CH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_req_i,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic          iop_req_i,
  input  logic          iop_we_i,
  input  logic [AW-1:0] iop_addr_i,
  input  logic [DW-1:0] iop_wdata_i,
  output logic [DW-1:0] iop_rdata_o,
  output logic          irq_o,
  output logic          doorbell_o,
  output logic          conflict_o
);
  // port 0 = host, port 1 = processor
  logic [1:0]             req, we;
  logic [1:0][AW-1:0]     addr;
  logic [1:0][DW-1:0]     wdata, buf_rd, st_rd, rdata_q;
  logic [1:0][BIDX_W-1:0] buf_idx;
  logic [1:0][SIDX_W-1:0] st_idx;
  logic [1:0]             buf_we, st_we, stat_we;
  logic [DW-1:0]          status;
  logic                   evt_send, evt_recv, clash;
  logic [1:0]             int_q, h_ack;
  logic                   h_ring, p_clr;

  assign req   = {iop_req_i, host_req_i};
  assign we    = {iop_we_i, host_we_i};
  assign addr  = {iop_addr_i, host_addr_i};
  assign wdata = {iop_wdata_i, host_wdata_i};

  for (genvar p = 0; p < 2; p++) begin : g_port
    dec_t              dec;
    logic [BIDX_W-1:0] bidx;
    logic [SIDX_W-1:0] sidx;
    logic [DW-1:0]     rd_d;

    mbx_dec #(.NUM_CH(NUM_CH), .MSG_BYTES(MSG_BYTES)) u_dec (
      .addr_i    (addr[p]),
      .dec_o     (dec),
      .buf_idx_o (bidx),
      .st_idx_o  (sidx)
    );

    assign buf_idx[p] = bidx;
    assign st_idx[p]  = sidx;
    assign buf_we[p]  = req[p] && we[p] && dec.buf_hit && dec.ch_ok;
    assign st_we[p]   = req[p] && we[p] && dec.st_hit && dec.ch_ok;
    assign stat_we[p] = req[p] && we[p] && dec.stat_hit;

    always_comb begin
      rd_d = '0;
      if (dec.buf_hit && dec.ch_ok)     rd_d = buf_rd[p];
      else if (dec.st_hit && dec.ch_ok) rd_d = st_rd[p];
      else if (dec.stat_hit)            rd_d = status;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               rdata_q[p] <= '0;
      else if (req[p] && !we[p]) rdata_q[p] <= rd_d;
    end
  end

  mbx_buf #(.NUM_CH(NUM_CH), .MSG_BYTES(MSG_BYTES)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (buf_we),
    .idx_i   (buf_idx),
    .wdata_i (wdata),
    .rdata_o (buf_rd)
  );

  mbx_state #(.NUM_CH(NUM_CH)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (st_we),
    .idx_i      (st_idx),
    .wdata_i    (wdata),
    .rdata_o    (st_rd),
    .evt_send_o (evt_send),
    .evt_recv_o (evt_recv),
    .clash_o    (clash)
  );

  assign h_ack  = {2{stat_we[0]}} & wdata[0][STAT_ARRV:STAT_DONE];
  assign h_ring = stat_we[0] && wdata[0][STAT_BELL];
  assign p_clr  = stat_we[1] && wdata[1][STAT_BELL];

  mbx_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_send_i (evt_send),
    .evt_recv_i (evt_recv),
    .ack_i      (h_ack),
    .ring_i     (h_ring),
    .bell_clr_i (p_clr),
    .clash_i    (clash),
    .int_o      (int_q),
    .bell_o     (doorbell_o),
    .err_o      (conflict_o)
  );

  always_comb begin
    status             = '0;
    status[STAT_DONE]  = int_q[0];
    status[STAT_ARRV]  = int_q[1];
    status[STAT_BELL]  = doorbell_o;
    status[STAT_CLASH] = conflict_o;
  end

  assign irq_o        = |int_q;
  assign host_rdata_o = rdata_q[0];
  assign iop_rdata_o  = rdata_q[1];
endmodule

// File: rtl/mbx_ctrl_chk.sv
module mbx_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       evt_send_i,
  input logic       evt_recv_i,
  input logic [1:0] int_i,
  input logic       irq_i,
  input logic [1:0] ack_i,
  input logic       ring_i,
  input logic       bell_clr_i,
  input logic       clash_i,
  input logic       bell_i,
  input logic       err_i
);
  // R4
  send_done_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_send_i |=> int_i[0]);
  // R5
  arrival_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_recv_i |=> int_i[1]);
  // R6
  done_needs_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_i[0]) |-> $past(evt_send_i));
  // R7
  irq_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $past(evt_send_i || evt_recv_i));
  // R8
  done_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i[0] && !evt_send_i) |=> !int_i[0]);
  // R8
  arrival_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i[1] && !evt_recv_i) |=> !int_i[1]);
  // R9
  bell_ring_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_i |=> bell_i);
  // R9
  bell_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bell_clr_i && !ring_i) |=> !bell_i);
  // R10
  clash_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clash_i |=> err_i);
  // R10
  clash_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> err_i);
endmodule

bind mbx_ctrl mbx_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_send_i (evt_send),
  .evt_recv_i (evt_recv),
  .int_i      (int_q),
  .irq_i      (irq_o),
  .ack_i      (h_ack),
  .ring_i     (h_ring),
  .bell_clr_i (p_clr),
  .clash_i    (clash),
  .bell_i     (doorbell_o),
  .err_i      (conflict_o)
);

// File: tb/mbx_ctrl_test.sv
`timescale 1ns/1ps
module mbx_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       h_req = 0, h_we = 0, p_req = 0, p_we = 0;
  logic [9:0] h_addr = '0, p_addr = '0;
  logic [7:0] h_wd = '0, p_wd = '0;
  logic [7:0] h_rd, p_rd;
  logic       irq, bell, clash;

  always #2 clk_i = ~clk_i;

  mbx_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .host_req_i(h_req), .host_we_i(h_we), .host_addr_i(h_addr),
    .host_wdata_i(h_wd), .host_rdata_o(h_rd),
    .iop_req_i(p_req), .iop_we_i(p_we), .iop_addr_i(p_addr),
    .iop_wdata_i(p_wd), .iop_rdata_o(p_rd),
    .irq_o(irq), .doorbell_o(bell), .conflict_o(clash)
  );

  int    errs = 0, checks = 0;
  bit    done = 0;
  string tag = "R1";

  logic [7:0] mem_m [512];
  logic [7:0] st_m  [16];
  logic m_i0 = 0, m_i1 = 0, m_db = 0, m_err = 0;
  logic [7:0] exp_hr = '0, exp_pr = '0;

  localparam logic [9:0] STAT = 10'h210;
  function automatic logic [9:0] st_a(int dir, int ch);
    return 10'(10'h200 | (dir << 3) | ch);
  endfunction
  function automatic logic [9:0] buf_a(int dir, int ch, int b);
    return 10'((dir << 8) | (ch << 5) | b);
  endfunction

  function automatic logic [7:0] mread(logic [9:0] a);
    if (!a[9]) return (a[7:5] == 3'd7) ? 8'h00 : mem_m[a[8:0]];
    if (a[8:4] == 5'd0) return (a[2:0] == 3'd7) ? 8'h00 : st_m[a[3:0]];
    if (a == STAT) return {4'b0, m_err, m_db, m_i1, m_i0};
    return 8'h00;
  endfunction

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  // reference step: inputs were set at the previous negedge
  task automatic tick();
    logic hs, ps, ev0, ev1, ring;
    @(posedge clk_i);
    if (h_req && !h_we) exp_hr = mread(h_addr);
    if (p_req && !p_we) exp_pr = mread(p_addr);
    hs = h_req && h_we && h_addr[9] && h_addr[8:4] == 0 && h_addr[2:0] != 3'd7;
    ps = p_req && p_we && p_addr[9] && p_addr[8:4] == 0 && p_addr[2:0] != 3'd7;
    if (hs && ps && h_addr == p_addr) begin
      m_err = 1;
      hs = 0;
    end
    ev0 = 0; ev1 = 0;
    if (hs) begin
      if (!h_addr[3] && h_wd == 8'd3 && st_m[h_addr[3:0]] != 8'd3) ev0 = 1;
      if (h_addr[3] && h_wd == 8'd1 && st_m[h_addr[3:0]] != 8'd1) ev1 = 1;
    end
    if (ps) begin
      if (!p_addr[3] && p_wd == 8'd3 && st_m[p_addr[3:0]] != 8'd3) ev0 = 1;
      if (p_addr[3] && p_wd == 8'd1 && st_m[p_addr[3:0]] != 8'd1) ev1 = 1;
    end
    if (hs) st_m[h_addr[3:0]] = h_wd;
    if (ps) st_m[p_addr[3:0]] = p_wd;
    if (h_req && h_we && !h_addr[9] && h_addr[7:5] != 3'd7) mem_m[h_addr[8:0]] = h_wd;
    if (p_req && p_we && !p_addr[9] && p_addr[7:5] != 3'd7) mem_m[p_addr[8:0]] = p_wd;
    ring = 0;
    if (h_req && h_we && h_addr == STAT) begin
      if (h_wd[0]) m_i0 = 0;
      if (h_wd[1]) m_i1 = 0;
      ring = h_wd[2];
    end
    if (p_req && p_we && p_addr == STAT && p_wd[2]) m_db = 0;
    if (ring) m_db = 1;
    m_i0 = m_i0 | ev0;
    m_i1 = m_i1 | ev1;
    @(negedge clk_i);
    chk("irq_o", {7'b0, irq}, {7'b0, m_i0 | m_i1});
    chk("doorbell_o", {7'b0, bell}, {7'b0, m_db});
    chk("conflict_o", {7'b0, clash}, {7'b0, m_err});
    chk("host_rdata_o", h_rd, exp_hr);
    chk("iop_rdata_o", p_rd, exp_pr);
  endtask

  task automatic drv(logic hq, logic hw, logic [9:0] ha, logic [7:0] hd,
                     logic pq, logic pw, logic [9:0] pa, logic [7:0] pd);
    h_req = hq; h_we = hw; h_addr = ha; h_wd = hd;
    p_req = pq; p_we = pw; p_addr = pa; p_wd = pd;
    tick();
    h_req = 0; h_we = 0; p_req = 0; p_we = 0;
  endtask

  task automatic hwr(logic [9:0] a, logic [7:0] d); drv(1, 1, a, d, 0, 0, '0, '0); endtask
  task automatic pwr(logic [9:0] a, logic [7:0] d); drv(0, 0, '0, '0, 1, 1, a, d); endtask
  task automatic hrd(logic [9:0] a); drv(1, 0, a, '0, 0, 0, '0, '0); endtask
  task automatic prd(logic [9:0] a); drv(0, 0, '0, '0, 1, 0, a, '0); endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL %s watchdog expired: actual 00 expected 01", tag);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) mem_m[i] = '0;
    for (int i = 0; i < 16; i++) st_m[i] = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1;

    // R1 reset state
    tag = "R1";
    chk("irq_o", {7'b0, irq}, 8'h00);
    chk("doorbell_o", {7'b0, bell}, 8'h00);
    chk("conflict_o", {7'b0, clash}, 8'h00);
    hrd(STAT);            chk("status", h_rd, 8'h00);
    prd(st_a(1, 4));      chk("state", p_rd, 8'h00);

    // R2 buffers, both directions
    tag = "R2";
    for (int i = 0; i < 32; i++) hwr(buf_a(0, 2, i), 8'(i * 7 + 3));
    for (int i = 0; i < 32; i++) begin
      prd(buf_a(0, 2, i));
      chk("buf readback", p_rd, 8'(i * 7 + 3));
    end
    pwr(buf_a(1, 5, 31), 8'h5C);
    hrd(buf_a(1, 5, 31)); chk("inbound byte", h_rd, 8'h5C);

    // R11 reserved channel and unmapped space
    tag = "R11";
    hwr(buf_a(0, 7, 4), 8'hFF);
    hwr(st_a(0, 7), 8'h03);
    hrd(buf_a(0, 7, 4));  chk("chan7 buf", h_rd, 8'h00);
    prd(st_a(0, 7));      chk("chan7 state", p_rd, 8'h00);
    hwr(10'h300, 8'hAA);
    hrd(10'h300);         chk("unmapped", h_rd, 8'h00);
    chk("irq after chan7", {7'b0, irq}, 8'h00);

    // R3 arbitrary value stored, no flag
    tag = "R3";
    hwr(st_a(0, 4), 8'hC7);
    prd(st_a(0, 4));      chk("state value", p_rd, 8'hC7);
    chk("irq for 0xC7", {7'b0, irq}, 8'h00);

    // R4 outbound handshake
    tag = "R4";
    hwr(st_a(0, 1), 8'd1);
    chk("irq after NEW", {7'b0, irq}, 8'h00);
    pwr(st_a(0, 1), 8'd2);
    pwr(st_a(0, 1), 8'd3);
    chk("irq after COMPLETE", {7'b0, irq}, 8'h01);
    hrd(STAT);            chk("status send-done", h_rd, 8'h01);

    // R8 acknowledge
    tag = "R8";
    hwr(STAT, 8'h01);
    chk("irq after ack", {7'b0, irq}, 8'h00);

    // R6 silent writes
    tag = "R6";
    pwr(st_a(0, 1), 8'd3);
    chk("same-value rewrite", {7'b0, irq}, 8'h00);
    pwr(st_a(1, 2), 8'd3);
    chk("COMPLETE inbound", {7'b0, irq}, 8'h00);
    hwr(st_a(0, 5), 8'd1);
    chk("NEW outbound", {7'b0, irq}, 8'h00);
    pwr(st_a(1, 6), 8'h81);
    chk("out of range", {7'b0, irq}, 8'h00);

    // R5 inbound handshake
    tag = "R5";
    pwr(st_a(1, 3), 8'd1);
    chk("irq after arrival", {7'b0, irq}, 8'h01);
    hrd(STAT);            chk("status arrival", h_rd, 8'h02);
    hwr(st_a(1, 3), 8'd2);
    hwr(st_a(1, 3), 8'd3);
    hwr(STAT, 8'h02);
    chk("irq after ack", {7'b0, irq}, 8'h00);
    pwr(st_a(1, 3), 8'd0);

    // R8 set beats ack, processor ack ignored
    tag = "R8";
    hwr(st_a(0, 1), 8'd0);
    drv(1, 1, STAT, 8'h01, 1, 1, st_a(0, 1), 8'd3);
    chk("set over ack", {7'b0, irq}, 8'h01);
    hwr(STAT, 8'h01);
    chk("ack clears", {7'b0, irq}, 8'h00);
    pwr(st_a(1, 0), 8'd1);
    pwr(STAT, 8'h03);
    chk("proc ack ignored", {7'b0, irq}, 8'h01);
    hwr(STAT, 8'h02);

    // R9 doorbell
    tag = "R9";
    hwr(STAT, 8'h04);
    chk("ring", {7'b0, bell}, 8'h01);
    pwr(STAT, 8'h04);
    chk("clear", {7'b0, bell}, 8'h00);
    drv(1, 1, STAT, 8'h04, 1, 1, STAT, 8'h04);
    chk("ring over clear", {7'b0, bell}, 8'h01);
    pwr(STAT, 8'h04);
    chk("clear again", {7'b0, bell}, 8'h00);

    // R10 same-byte clash
    tag = "R10";
    drv(1, 1, st_a(1, 6), 8'd1, 1, 1, st_a(1, 6), 8'd2);
    chk("conflict set", {7'b0, clash}, 8'h01);
    chk("host NEW discarded", {7'b0, irq}, 8'h00);
    hrd(st_a(1, 6));      chk("proc value kept", h_rd, 8'h02);
    drv(1, 1, st_a(0, 0), 8'd3, 1, 1, st_a(1, 0), 8'd0);
    drv(1, 1, st_a(0, 6), 8'd3, 1, 1, st_a(1, 0), 8'd1);
    chk("conflict sticky", {7'b0, clash}, 8'h01);

    // R7 status layout and irq as OR
    tag = "R7";
    hrd(STAT);            chk("status both", h_rd, 8'h0B);
    hwr(STAT, 8'h01);
    chk("irq one left", {7'b0, irq}, 8'h01);
    hwr(STAT, 8'h02);
    chk("irq none left", {7'b0, irq}, 8'h00);

    // mixed random traffic against the model
    tag = "R2 mix";
    for (int n = 0; n < 3000; n++) begin
      logic [9:0] a[2];
      logic [7:0] d[2];
      logic       q[2], w[2];
      for (int p = 0; p < 2; p++) begin
        int k = $urandom_range(0, 9);
        q[p] = ($urandom_range(0, 3) != 0);
        w[p] = $urandom_range(0, 1) == 1;
        d[p] = 8'($urandom);
        if (k < 4)       a[p] = 10'($urandom_range(0, 511));
        else if (k < 8) begin
          a[p] = 10'(10'h200 | $urandom_range(0, 15));
          if ($urandom_range(0, 3) != 0) d[p] = 8'($urandom_range(0, 3));
        end else if (k < 9) a[p] = STAT;
        else a[p] = 10'($urandom_range(10'h211, 10'h3FF));
      end
      drv(q[0], w[0], a[0], d[0], q[1], w[1], a[1], d[1]);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule